// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block sits between up to 32 peripheral interrupt lines and a small CPU core. It picks one pending request and presents it to the core as a vector number together with the address of that vector's table entry. The core accepts the offered vector with an acknowledge pulse. When the handler finishes, the core sends a return pulse.

Requests are served at two levels. Every vector is at the normal level unless software writes its vector number into the high-level select register. That one vector can then preempt a normal-level handler that is running. The block keeps an in-service flag for each level and does not use a global interrupt enable. A set flag suspends new requests of the same level and of lower levels until a return pulse clears it. As a result, a handler that waits for a high-level event does not block that event.

Normal-level arbitration is either fixed, where the lowest number wins, or round-robin, where the search starts just after the last acknowledged normal vector. A combinational wake output tells the sleep logic that a request is present which the current in-service state would accept.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `cpu_req_o`, `wake_o`, `lvl0_busy_o` and `lvl1_busy_o` are 0, and the high-level select register holds 0. With that value no vector is at the high level.
- R2: Line 0 is reserved for reset. A request on line 0 alone never raises `cpu_req_o` or `wake_o`, and vector 0 is never offered.
- R3: With `rr_en_i`=0, the lowest-numbered pending normal-level vector is offered. `cpu_vec_o` carries the vector number in binary.
- R4: While `lvl0_busy_o` is 1 and `lvl1_busy_o` is 0, no normal-level vector is offered and normal-level requests do not raise `wake_o`.
- R5: The high-level select register, written through `cfg_we_i` and `cfg_hi_vec_i`, holds a plain vector number N. It does not hold an address. A pending request on line N is offered ahead of every normal-level request, including lower-numbered ones, and it is offered even while `lvl0_busy_o` is 1.
- R6: While `lvl1_busy_o` is 1, nothing is offered and `wake_o` stays 0.
- R7: An acknowledge while a vector is offered sets the in-service flag of that vector's level. In the cycle after the acknowledge, `cpu_req_o` is 0.
- R8: A return pulse clears `lvl1_busy_o` if it is set, and leaves `lvl0_busy_o` unchanged. A normal-level handler that was preempted therefore stays in service. Otherwise the pulse clears `lvl0_busy_o`.
- R9: A return pulse while neither in-service flag is set has no effect.
- R10: With `rr_en_i`=1, the normal-level search starts at the vector just after the last acknowledged normal-level vector and wraps past the highest line.
- R11: `cpu_addr_o` equals `cpu_vec_o`×2 when `entry4_i`=0 and `cpu_vec_o`×4 when `entry4_i`=1.
- R12: `wake_o` is 1 in the same cycle that a request exists which the current in-service flags allow to be taken. `cpu_req_o` follows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Level-held interrupt request lines |
| cfg_we_i | input | 1 | Write strobe for the high-level select register |
| cfg_hi_vec_i | input | 5 | Vector number to place at the high level (0 = none) |
| rr_en_i | input | 1 | Round-robin arbitration among normal-level vectors |
| entry4_i | input | 1 | Vector table entry size: 0 = 2 bytes, 1 = 4 bytes |
| cpu_ack_i | input | 1 | Core accepts the offered vector |
| cpu_reti_i | input | 1 | Core returns from the current handler |
| cpu_req_o | output | 1 | A vector is offered |
| cpu_vec_o | output | 5 | Offered vector number |
| cpu_addr_o | output | 7 | Fetch address of the offered vector's table entry |
| lvl0_busy_o | output | 1 | Normal-level handler in service |
| lvl1_busy_o | output | 1 | High-level handler in service |
| wake_o | output | 1 | Acceptable request present |

## Verification
The assertions assume a well-behaved core. It acknowledges only while `cpu_req_o` is 1 and sends no more return pulses than acknowledges. They also assume that a peripheral holds its line until its handler clears it. The bench drives every input on the falling edge. It raises acknowledge only after it has seen the offer, and it drops a request line only after that request has been acknowledged. It pairs every return pulse with an earlier acknowledge, except for the one deliberate stray pulse that exercises R9.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic {
        LVL_NORM = 1'b0,
        LVL_HIGH = 1'b1
    } prio_lvl_e;

    typedef enum logic {
        ENTRY_2B = 1'b0,
        ENTRY_4B = 1'b1
    } entry_sz_e;

endpackage

// File: rtl/irq_cand_mask.sv
// Splits the raw request lines into the high-level candidate and the
// set of normal-level candidates allowed by the in-service flags.
module irq_cand_mask #(
    parameter int NUM_VEC = 32,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] irq_i,
    input  logic [VEC_W-1:0]   hi_vec_i,
    input  logic               busy0_i,
    input  logic               busy1_i,
    output logic               hi_hit_o,
    output logic [NUM_VEC-1:0] norm_mask_o
);

    logic               hi_sel_ok;
    logic [NUM_VEC-1:0] hi_onehot;

    assign hi_sel_ok = (hi_vec_i != '0) && (int'(hi_vec_i) < NUM_VEC);

    always_comb begin
        hi_onehot = '0;
        for (int i = 1; i < NUM_VEC; i++) begin
            if (hi_sel_ok && (int'(hi_vec_i) == i)) hi_onehot[i] = 1'b1;
        end
    end

    assign hi_hit_o = !busy1_i && |(irq_i & hi_onehot);

    always_comb begin
        norm_mask_o = irq_i & ~hi_onehot;
        norm_mask_o[0] = 1'b0;
        if (busy0_i || busy1_i) norm_mask_o = '0;
    end

endmodule

// File: rtl/irq_norm_arb.sv
// Normal-level winner: lowest index, or search starting after last grant.
module irq_norm_arb #(
    parameter int NUM_VEC = 32,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] mask_i,
    input  logic               rr_en_i,
    input  logic [VEC_W-1:0]   last_i,
    output logic               valid_o,
    output logic [VEC_W-1:0]   idx_o
);

    int start_pos;

    always_comb begin
        start_pos = rr_en_i ? ((int'(last_i) + 1) % NUM_VEC) : 0;
        valid_o   = 1'b0;
        idx_o     = '0;
        for (int k = 0; k < NUM_VEC; k++) begin
            int pos;
            pos = (start_pos + k) % NUM_VEC;
            if (!valid_o && mask_i[pos]) begin
                valid_o = 1'b1;
                idx_o   = VEC_W'(pos);
            end
        end
    end

    AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> mask_i[idx_o]) else $error("winner not pending"); // R3
    AST_NO_LOST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i != '0) |-> valid_o) else $error("pending request lost"); // R10

endmodule

// File: rtl/irq_vec_addr.sv
// Vector table fetch address from vector number and entry size.
module irq_vec_addr #(
    parameter int VEC_W  = 5,
    parameter int ADDR_W = VEC_W + 2
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              entry4_i,
    output logic [ADDR_W-1:0] addr_o
);

    import irq_prio_pkg::*;

    entry_sz_e sz;
    assign sz = entry_sz_e'(entry4_i);

    always_comb begin
        if (sz == ENTRY_4B) addr_o = {vec_i, 2'b00};
        else                addr_o = {1'b0, vec_i, 1'b0};
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_VEC = 32,
    parameter int VEC_W   = $clog2(NUM_VEC),
    parameter int ADDR_W  = VEC_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_i,
    input  logic               cfg_we_i,
    input  logic [VEC_W-1:0]   cfg_hi_vec_i,
    input  logic               rr_en_i,
    input  logic               entry4_i,
    input  logic               cpu_ack_i,
    input  logic               cpu_reti_i,
    output logic               cpu_req_o,
    output logic [VEC_W-1:0]   cpu_vec_o,
    output logic [ADDR_W-1:0]  cpu_addr_o,
    output logic               lvl0_busy_o,
    output logic               lvl1_busy_o,
    output logic               wake_o
);

    import irq_prio_pkg::*;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        prio_lvl_e        lvl;
        logic             busy0;
        logic             busy1;
        logic [VEC_W-1:0] last;
        logic [VEC_W-1:0] hi;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic               hi_hit;
    logic [NUM_VEC-1:0] norm_mask;
    logic               norm_valid;
    logic [VEC_W-1:0]   norm_idx;
    logic               win_valid;

    irq_cand_mask #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_mask (
        .irq_i       (irq_i),
        .hi_vec_i    (ctl_q.hi),
        .busy0_i     (ctl_q.busy0),
        .busy1_i     (ctl_q.busy1),
        .hi_hit_o    (hi_hit),
        .norm_mask_o (norm_mask)
    );

    irq_norm_arb #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_i  (norm_mask),
        .rr_en_i (rr_en_i),
        .last_i  (ctl_q.last),
        .valid_o (norm_valid),
        .idx_o   (norm_idx)
    );

    irq_vec_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_addr (
        .vec_i    (ctl_q.vec),
        .entry4_i (entry4_i),
        .addr_o   (cpu_addr_o)
    );

    assign win_valid = hi_hit || norm_valid;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we_i) ctl_d.hi = cfg_hi_vec_i;
        // return first, so an ack in the same cycle can set a flag again
        if (cpu_reti_i) begin
            if (ctl_q.busy1)      ctl_d.busy1 = 1'b0;
            else if (ctl_q.busy0) ctl_d.busy0 = 1'b0;
        end
        if (cpu_ack_i && ctl_q.req) begin
            if (ctl_q.lvl == LVL_HIGH) begin
                ctl_d.busy1 = 1'b1;
            end else begin
                ctl_d.busy0 = 1'b1;
                ctl_d.last  = ctl_q.vec;
            end
        end
        ctl_d.req = win_valid && !cpu_ack_i;
        if (win_valid) begin
            ctl_d.vec = hi_hit ? ctl_q.hi : norm_idx;
            ctl_d.lvl = hi_hit ? LVL_HIGH : LVL_NORM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{req: 1'b0, vec: '0, lvl: LVL_NORM, busy0: 1'b0,
                               busy1: 1'b0, last: '0, hi: '0};
        else        ctl_q <= ctl_d;
    end

    assign cpu_req_o   = ctl_q.req;
    assign cpu_vec_o   = ctl_q.vec;
    assign lvl0_busy_o = ctl_q.busy0;
    assign lvl1_busy_o = ctl_q.busy1;
    assign wake_o      = win_valid;

    AST_NO_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> (cpu_vec_o != '0)) else $error("vector 0 offered"); // R2
    AST_L0_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && lvl0_busy_o) |-> (ctl_q.lvl == LVL_HIGH)) else $error("level-0 nested"); // R4
    AST_HIGH_IS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && ctl_q.lvl == LVL_HIGH && !$past(cfg_we_i)) |-> (cpu_vec_o == ctl_q.hi)) else $error("high vector mismatch"); // R5
    AST_L1_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        lvl1_busy_o |-> (!cpu_req_o && !wake_o)) else $error("offer while level 1 busy"); // R6
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_i && cpu_req_o) |=> !cpu_req_o) else $error("req held after ack"); // R7
    AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_i && cpu_req_o) |=> (lvl0_busy_o || lvl1_busy_o)) else $error("ack set no flag"); // R7
    AST_RETI_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti_i && !cpu_ack_i && lvl1_busy_o && lvl0_busy_o) |=> (!lvl1_busy_o && lvl0_busy_o)) else $error("wrong level released"); // R8
    AST_RETI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti_i && !cpu_ack_i && !lvl0_busy_o && !lvl1_busy_o) |=> (!lvl0_busy_o && !lvl1_busy_o)) else $error("stray return changed flags"); // R9
    AST_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> (cpu_addr_o != '0 && cpu_addr_o[0] == 1'b0)) else $error("bad fetch address"); // R11
    AST_REQ_FOLLOWS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_o && !lvl1_busy_o) |=> !cpu_req_o) else $error("req without wake"); // R12

endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_hi = '0;
    logic        rr_en = 1'b0;
    logic        entry4 = 1'b0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        req;
    logic [4:0]  vec;
    logic [6:0]  addr;
    logic        busy0, busy1, wake;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we),
        .cfg_hi_vec_i(cfg_hi), .rr_en_i(rr_en), .entry4_i(entry4),
        .cpu_ack_i(ack), .cpu_reti_i(reti), .cpu_req_o(req),
        .cpu_vec_o(vec), .cpu_addr_o(addr), .lvl0_busy_o(busy0),
        .lvl1_busy_o(busy1), .wake_o(wake)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic pulse_ack(); ack = 1'b1; step(); ack = 1'b0; endtask
    task automatic pulse_reti(); reti = 1'b1; step(); reti = 1'b0; endtask
    task automatic set_hi(input logic [4:0] v);
        cfg_hi = v; cfg_we = 1'b1; step(); cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req", req, 0);
        chk("R1 busy0", busy0, 0);
        chk("R1 busy1", busy1, 0);
        chk("R1 wake", wake, 0);
    endtask

    task automatic t_line0();
        irq = 32'h1; #1;
        chk("R2 wake line0", wake, 0);
        step();
        chk("R2 req line0", req, 0);
        irq = '0; step();
    endtask

    task automatic t_fixed_addr();
        irq = (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 3); #1;
        chk("R12 wake same cycle", wake, 1);
        step();
        chk("R3 req", req, 1);
        chk("R3 lowest wins", vec, 3);
        chk("R11 addr 2B", addr, 6);
        entry4 = 1'b1; #1;
        chk("R11 addr 4B", addr, 12);
        entry4 = 1'b0;
    endtask

    task automatic t_block_l0();
        pulse_ack();
        irq[3] = 1'b0;
        chk("R7 busy0 set", busy0, 1);
        chk("R7 req dropped", req, 0);
        #1;
        chk("R4 wake blocked", wake, 0);
        step();
        chk("R4 no level0 offer", req, 0);
    endtask

    task automatic t_preempt();
        set_hi(5'd9);
        step();
        chk("R5 high offered under busy0", req, 1);
        chk("R5 vector number 9", vec, 9);
        chk("R11 addr high", addr, 18);
        pulse_ack();
        irq[9] = 1'b0;
        chk("R7 busy1 set", busy1, 1);
        chk("R7 busy0 kept", busy0, 1);
        irq[9] = 1'b1; #1;
        chk("R6 wake blocked", wake, 0);
        step();
        chk("R6 no offer", req, 0);
        irq[9] = 1'b0;
        pulse_reti();
        chk("R8 busy1 cleared", busy1, 0);
        chk("R8 busy0 kept", busy0, 1);
        pulse_reti();
        chk("R8 busy0 cleared", busy0, 0);
        step();
        chk("R3 remaining", vec, 5);
        chk("R3 remaining req", req, 1);
        pulse_ack(); irq[5] = 1'b0; pulse_reti();
        set_hi(5'd0);
        irq = '0; step();
    endtask

    task automatic t_high_over_low();
        set_hi(5'd20);
        irq = (32'h1 << 20) | (32'h1 << 2);
        step();
        chk("R5 high beats lower number", vec, 20);
        pulse_ack(); irq[20] = 1'b0;
        pulse_reti(); step();
        chk("R5 then normal", vec, 2);
        pulse_ack(); irq = '0; pulse_reti();
        set_hi(5'd0); step();
    endtask

    task automatic t_stray_reti();
        pulse_reti();
        chk("R9 busy0", busy0, 0);
        chk("R9 busy1", busy1, 0);
        irq[7] = 1'b1; step();
        chk("R9 later grant", vec, 7);
        pulse_ack(); irq = '0; pulse_reti(); step();
    endtask

    task automatic t_round_robin();
        int exp_seq[4] = '{2, 4, 7, 2};
        irq = (32'h1 << 2) | (32'h1 << 4) | (32'h1 << 7);
        rr_en = 1'b0; step();
        pulse_ack(); pulse_reti(); step();
        chk("R3 fixed repeats", vec, 2);
        pulse_ack(); pulse_reti();
        rr_en = 1'b1; step();
        // last acknowledged was 2, so search starts at 3
        chk("R10 after 2", vec, 4);
        pulse_ack(); pulse_reti(); step();
        chk("R10 after 4", vec, 7);
        pulse_ack(); pulse_reti(); step();
        chk("R10 wrap", vec, exp_seq[3]);
        pulse_ack(); irq = '0; pulse_reti();
        rr_en = 1'b0; step();
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst_n = 1'b1;
                step();
                t_reset();
                t_line0();
                t_fixed_addr();
                t_block_l0();
                t_preempt();
                t_high_over_low();
                t_stray_reti();
                t_round_robin();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule